// File: doc/BRIEF.md
# Shadowed Serial Register Update Engine

This block keeps the write-only registers of an external sound chip in step with a local register file. The chip cannot be read back, so the engine holds a shadow copy of every register. On each scan pass it visits the registers in a fixed, computed order and compares each live value with its shadow. A register is sent when the two differ, or in every case when the pass was started with a forced refresh. The shadow is updated before the frame leaves.

Each update is a 16-bit serial frame: an address byte followed by a data byte. The frame is clocked into an external shift register and then moved to its parallel outputs by a latch pulse. The engine then waits for a falling edge of the chip's own clock, after a two-flop synchroniser. Only then does it pull an active-low write strobe low, and it holds the strobe low for longer than one chip clock period. After reset, an all-zero frame is sent once, which drives the chip's reset line low. The first normal frame releases it.

Top module: `shadow_sync_engine`

## Requirements
- R1: Within a pass, slot k (k = 0..NREG-1) visits register k^1, or register k when k^1 >= NREG. With 10 registers the order is 1,0,3,2,5,4,7,6,9,8.
- R2: With the force flag clear, a register is sent only when its live value differs from its shadow at the moment it is visited. A value that changes and changes back before the pass is not sent.
- R3: A pass started with the force flag set sends every register, whatever its shadow holds.
- R4: On a transfer the shadow takes the sent value, so a repeated unforced pass with unchanged inputs sends nothing. Shadows reset to zero.
- R5: A frame is 16 bits, MSB first, address byte before data byte. The address byte is 0xE0 OR the register address: bits 4..0 hold the address, bit 5 is the chip's active-low reset (1 = released), and bits 7..6 are 1.
- R6: The serial data pin is valid at each serial clock rising edge. One latch clock pulse follows the 16th rising edge. The data pin is low when the latch pulse ends, and the serial and latch clocks are never high together.
- R7: The write strobe falls only in the cycle after a synchronised falling edge of the chip clock. It falls 1 to 4 system cycles after the chip clock goes low, while the chip clock is still low.
- R8: The write strobe stays low for exactly STROBE_LEN system cycles, longer than one chip clock period. No serial or latch clock activity occurs while it is low.
- R9: After reset, and before any pass, one frame of 16'h0000 is sent and strobed, driving the reset bit low.
- R10: busy is high from the cycle after an accepted start, or during the reset frame, until the work ends. A start pulse is accepted only while busy is low; a start during a pass has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a scan pass (only while idle) |
| force_i | input | 1 | Sampled with start: send every register |
| regs_i | input | NREG*DW | Live register file, register r at bits [r*DW +: DW] |
| chip_clk_i | input | 1 | Remote chip clock, asynchronous |
| busy_o | output | 1 | Engine working |
| sclk_o | output | 1 | Serial shift clock |
| sdata_o | output | 1 | Serial data |
| rclk_o | output | 1 | Latch clock of the external shift register |
| wr_n_o | output | 1 | Active-low write strobe to the chip |

## Verification
Passes are run with all-zero registers both forced and unforced. The forced run separates the force path from change detection, and the unforced repeat shows that the shadow was written. Sparse changes are placed at the start, middle and end of the visit order, and every register is changed in one pass. These show the order and that only differing registers go out. One register is changed and restored before a pass, to show that the compare uses the shadow and not edge history. A start pulse during a busy pass checks that a second pass is not queued. Every strobe is timed against the modelled chip clock, and every latched word is compared against the scoreboard.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_CHECK,
      ENG_SHIFT,
      ENG_WAIT_FALL,
      ENG_STROBE,
      ENG_NEXT
   } eng_state_t;

   typedef enum logic [1:0] {
      SH_IDLE,
      SH_LOW,
      SH_HIGH,
      SH_LATCH
   } sh_state_t;

   // Visit order: neighbouring pairs swapped, an unpaired last entry stays put.
   function automatic int unsigned visit_slot(int unsigned k, int unsigned n);
      int unsigned partner;
      partner = k ^ 32'd1;
      return (partner < n) ? partner : k;
   endfunction

endpackage

// File: rtl/ssu_edge_sync.sv
module ssu_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic fall_o
);
   logic [STAGES:0] pipe_q;

   initial begin
      if (STAGES < 2) $error("ssu_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
   end

   // Synchronised level is pipe_q[STAGES-1]; pipe_q[STAGES] is its previous value.
   assign fall_o = pipe_q[STAGES] & ~pipe_q[STAGES-1];
endmodule

// File: rtl/ssu_frame_shifter.sv
module ssu_frame_shifter #(
   parameter int FW        = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [FW-1:0] frame_i,
   output logic          sclk_o,
   output logic          sdata_o,
   output logic          rclk_o,
   output logic          done_o
);
   import ssu_pkg::*;

   localparam int CW = $clog2(FW);

   sh_state_t     st_q;
   logic [FW-1:0] sr_q;
   logic [FW-1:0] sr_shift;
   logic [CW-1:0] cnt_q;
   logic          head_load;
   logic          head_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_shift  = {sr_q[FW-2:0], 1'b0};
         assign head_load = frame_i[FW-1];
         assign head_next = sr_q[FW-2];
      end else begin : g_lsb
         assign sr_shift  = {1'b0, sr_q[FW-1:1]};
         assign head_load = frame_i[0];
         assign head_next = sr_q[1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SH_IDLE;
         sr_q    <= '0;
         cnt_q   <= '0;
         sclk_o  <= 1'b0;
         sdata_o <= 1'b0;
         rclk_o  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            SH_IDLE: begin
               if (go_i) begin
                  sr_q    <= frame_i;
                  sdata_o <= head_load;
                  cnt_q   <= '0;
                  st_q    <= SH_LOW;
               end
            end
            SH_LOW: begin
               sclk_o <= 1'b1;
               st_q   <= SH_HIGH;
            end
            SH_HIGH: begin
               sclk_o <= 1'b0;
               if (cnt_q == CW'(FW-1)) begin
                  rclk_o  <= 1'b1;
                  sdata_o <= 1'b0;
                  st_q    <= SH_LATCH;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
                  sr_q    <= sr_shift;
                  sdata_o <= head_next;
                  st_q    <= SH_LOW;
               end
            end
            SH_LATCH: begin
               rclk_o <= 1'b0;
               done_o <= 1'b1;
               st_q   <= SH_IDLE;
            end
            default: st_q <= SH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/shadow_sync_engine.sv
module shadow_sync_engine #(
   parameter int NREG        = 10,
   parameter int DW          = 8,
   parameter int AW          = 5,
   parameter int STROBE_LEN  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              force_i,
   input  logic [NREG*DW-1:0] regs_i,
   input  logic              chip_clk_i,
   output logic              busy_o,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              rclk_o,
   output logic              wr_n_o
);
   import ssu_pkg::*;

   localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int FW  = 2 * DW;
   localparam int SCW = $clog2(STROBE_LEN + 1);

   initial begin
      if (NREG < 2 || NREG > (1 << AW)) $error("shadow_sync_engine: NREG out of range");
      if (AW >= DW)                     $error("shadow_sync_engine: AW must leave room for the reset bit");
      if (STROBE_LEN < 2)               $error("shadow_sync_engine: STROBE_LEN too short");
   end

   eng_state_t     st_q;
   logic [IW-1:0]  k_q;
   logic [IW-1:0]  slot;
   logic [DW-1:0]  live;
   logic [DW-1:0]  shadow_q [NREG];
   logic [FW-1:0]  frame_q;
   logic [SCW-1:0] scnt_q;
   logic           go_q;
   logic           force_q;
   logic           init_q;
   logic           pass_q;
   logic           shift_done;
   logic           chip_fall;

   assign slot = IW'(visit_slot(32'(k_q), NREG));
   assign live = regs_i[32'(slot)*DW +: DW];

   ssu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(chip_clk_i),
      .fall_o (chip_fall)
   );

   ssu_frame_shifter #(.FW(FW), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go_q),
      .frame_i(frame_q),
      .sclk_o (sclk_o),
      .sdata_o(sdata_o),
      .rclk_o (rclk_o),
      .done_o (shift_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ENG_IDLE;
         k_q     <= '0;
         frame_q <= '0;
         scnt_q  <= '0;
         go_q    <= 1'b0;
         force_q <= 1'b0;
         init_q  <= 1'b1;
         pass_q  <= 1'b0;
         wr_n_o  <= 1'b1;
         for (int r = 0; r < NREG; r++) shadow_q[r] <= '0;
      end else begin
         go_q <= 1'b0;
         unique case (st_q)
            ENG_IDLE: begin
               if (init_q) begin
                  init_q  <= 1'b0;
                  frame_q <= '0;
                  go_q    <= 1'b1;
                  st_q    <= ENG_SHIFT;
               end else if (start_i) begin
                  k_q     <= '0;
                  force_q <= force_i;
                  pass_q  <= 1'b1;
                  st_q    <= ENG_CHECK;
               end
            end
            ENG_CHECK: begin
               if (force_q || live != shadow_q[slot]) begin
                  shadow_q[slot] <= live;
                  frame_q <= {{(DW-AW){1'b1}}, AW'(slot), live};
                  go_q    <= 1'b1;
                  st_q    <= ENG_SHIFT;
               end else begin
                  st_q <= ENG_NEXT;
               end
            end
            ENG_SHIFT: begin
               if (shift_done) st_q <= ENG_WAIT_FALL;
            end
            ENG_WAIT_FALL: begin
               if (chip_fall) begin
                  wr_n_o <= 1'b0;
                  scnt_q <= '0;
                  st_q   <= ENG_STROBE;
               end
            end
            ENG_STROBE: begin
               if (scnt_q == SCW'(STROBE_LEN-1)) begin
                  wr_n_o <= 1'b1;
                  st_q   <= pass_q ? ENG_NEXT : ENG_IDLE;
               end else begin
                  scnt_q <= scnt_q + 1'b1;
               end
            end
            ENG_NEXT: begin
               if (k_q == IW'(NREG-1)) begin
                  pass_q <= 1'b0;
                  st_q   <= ENG_IDLE;
               end else begin
                  k_q  <= k_q + 1'b1;
                  st_q <= ENG_CHECK;
               end
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ENG_IDLE);
endmodule

// File: rtl/ssu_engine_checker.sv
module ssu_engine_checker #(
   parameter int STROBE_LEN = 16
) (
   input logic clk,
   input logic rst_n,
   input logic sclk_o,
   input logic sdata_o,
   input logic rclk_o,
   input logic wr_n_o,
   input logic chip_fall
);
   logic [15:0] low_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_cnt_q <= '0;
      else if (wr_n_o) low_cnt_q <= '0;
      else if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
   end

   AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n_o) |-> $past(chip_fall)); // R7

   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n_o) |-> (low_cnt_q == 16'(STROBE_LEN))); // R8

   AST_QUIET_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n_o |-> (!sclk_o && !rclk_o)); // R8

   AST_CLOCKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk_o && rclk_o)); // R6

   AST_DATA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rclk_o) |-> !sdata_o); // R6
endmodule

bind shadow_sync_engine ssu_engine_checker #(.STROBE_LEN(STROBE_LEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk_o   (sclk_o),
   .sdata_o  (sdata_o),
   .rclk_o   (rclk_o),
   .wr_n_o   (wr_n_o),
   .chip_fall(chip_fall)
);

// File: tb/shadow_sync_engine_bench.sv
module shadow_sync_engine_bench;
   localparam int CLK_PERIOD    = 10;
   localparam int CHIP_HALF_CYC = 6;
   localparam int NREG          = 10;
   localparam int DW            = 8;
   localparam int STROBE_LEN    = 16;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic              force_i;
   logic [NREG*DW-1:0] regs_i;
   logic              chip_clk_i = 1'b1;
   logic              busy_o, sclk_o, sdata_o, rclk_o, wr_n_o;

   logic [DW-1:0] live [NREG];
   logic [DW-1:0] bsh  [NREG];

   always_comb begin
      for (int r = 0; r < NREG; r++) regs_i[r*DW +: DW] = live[r];
   end

   shadow_sync_engine #(.NREG(NREG), .DW(DW), .STROBE_LEN(STROBE_LEN)) u_shadow_sync_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .force_i(force_i), .regs_i(regs_i),
      .chip_clk_i(chip_clk_i), .busy_o(busy_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
      .rclk_o(rclk_o), .wr_n_o(wr_n_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #2;
      forever #(CHIP_HALF_CYC*CLK_PERIOD) chip_clk_i = ~chip_clk_i;
   end

   int checks = 0;
   int fails  = 0;
   int writes = 0;
   int cyc    = 0;
   bit finished = 1'b0;
   logic [15:0] exp_q [$];

   // External shift register, latch and strobe monitor
   logic [15:0] shreg = '0, latched = '0;
   logic sclk_p = 1'b0, rclk_p = 1'b0, wr_p = 1'b1, chip_p = 1'b1;
   int last_fall = -100;
   int low_len = 0;

   always @(negedge clk) begin
      cyc++;
      if (chip_p && !chip_clk_i) last_fall = cyc;
      if (!sclk_p && sclk_o) shreg = {shreg[14:0], sdata_o};
      if (!rclk_p && rclk_o) latched = shreg;
      if (wr_p && !wr_n_o) begin
         writes++;
         checks++;
         if ((cyc - last_fall) < 1 || (cyc - last_fall) > 4 || chip_clk_i) begin
            fails++;
            $display("FAIL R7 strobe delay after chip fall: actual %0d cycles (chip=%b), expected 1..4 with chip low",
                     cyc - last_fall, chip_clk_i);
         end
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2 unexpected write: actual %h, expected none", latched);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            if (latched !== e) begin
               fails++;
               $display("FAIL R1 R5 latched word: actual %h, expected %h", latched, e);
            end
         end
         low_len = 0;
      end
      if (!wr_n_o) low_len++;
      if (!wr_p && wr_n_o) begin
         checks++;
         if (low_len < 2*CHIP_HALF_CYC || low_len != STROBE_LEN) begin
            fails++;
            $display("FAIL R8 strobe width: actual %0d, expected %0d", low_len, STROBE_LEN);
         end
      end
      sclk_p = sclk_o; rclk_p = rclk_o; wr_p = wr_n_o; chip_p = chip_clk_i;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog: actual timeout, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   function automatic int slot_of(int k);
      int p;
      p = (k % 2 == 0) ? k + 1 : k - 1;
      return (p < NREG) ? p : k;
   endfunction

   task automatic check_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d, expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Driver: push expectations, run a pass, compare counts
   task automatic run_pass(bit frc, string tag, bit extra_start);
      int n = 0;
      int w0;
      for (int k = 0; k < NREG; k++) begin
         int s = slot_of(k);
         if (frc || live[s] != bsh[s]) begin
            exp_q.push_back({8'hE0 | 8'(s), live[s]});
            bsh[s] = live[s];
            n++;
         end
      end
      w0 = writes;
      @(negedge clk); start_i = 1'b1; force_i = frc;
      @(negedge clk); start_i = 1'b0; force_i = 1'b0;
      check_val({tag, " R10 busy after start"}, int'(busy_o), 1);
      if (extra_start) begin
         repeat (20) @(negedge clk);
         start_i = 1'b1; force_i = 1'b1;
         @(negedge clk); start_i = 1'b0; force_i = 1'b0;
      end
      wait_idle();
      check_val({tag, " write count"}, writes - w0, n);
      check_val({tag, " scoreboard drained"}, exp_q.size(), 0);
   endtask

   initial begin
      bit saw_busy;
      rst_n = 1'b0; start_i = 1'b0; force_i = 1'b0;
      for (int r = 0; r < NREG; r++) begin live[r] = '0; bsh[r] = '0; end
      repeat (5) @(negedge clk);
      check_val("reset wr_n", int'(wr_n_o), 1);
      check_val("reset sclk/rclk", int'(sclk_o | rclk_o), 0);
      check_val("R10 reset busy", int'(busy_o), 0);

      // R9: all-zero frame with reset bit low goes out first
      exp_q.push_back(16'h0000);
      rst_n = 1'b1;
      wait_idle();
      check_val("R9 init frame count", writes, 1);
      check_val("R9 init drained", exp_q.size(), 0);

      run_pass(1'b1, "R3 forced zeros", 1'b0);
      run_pass(1'b0, "R4 unchanged repeat", 1'b0);

      live[3] = 8'h5A; live[8] = 8'hC3;
      run_pass(1'b0, "R2 sparse change", 1'b0);

      for (int r = 0; r < NREG; r++) live[r] = 8'(r*17 + 1);
      run_pass(1'b0, "R1 all changed", 1'b0);

      live[0] = 8'hFF; live[9] = 8'h00;
      run_pass(1'b0, "R10 ends with extra start", 1'b1);
      saw_busy = 1'b0;
      repeat (60) begin
         @(negedge clk);
         if (busy_o) saw_busy = 1'b1;
      end
      check_val("R10 start during pass ignored", int'(saw_busy), 0);

      live[5] = 8'h99;
      repeat (3) @(negedge clk);
      live[5] = 8'(5*17 + 1);
      run_pass(1'b0, "R2 change and restore", 1'b0);

      live[2] = 8'hA5;
      run_pass(1'b1, "R3 forced with values", 1'b0);
      run_pass(1'b0, "R4 after forced", 1'b0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule